// File: doc/BRIEF.md
# Pipeline Hazard and Bypass Unit

This block checks register dependencies for the decode stage of a five-stage in-order RV32 pipeline (fetch, decode, execute, memory, writeback). The decode stage presents up to two source register indices, each with a flag saying whether the instruction actually reads it. The block compares each index with the destination of every younger-to-older producer: the execute stage, the memory stage, the writeback stage, and a one-entry hold register. That hold register keeps the register-file write made on the previous cycle. For each source it then either hands decode a forwarded value or raises a stall.

The hold register exists because the register file gives an undefined result when a read and a write hit the same address. It also may not yet show a value written one cycle earlier. Forwarding from each producer (execute, memory, writeback, hold) is switched on or off by its own parameter. A producer also flags whether its result is ready. Load and multiply results become ready only in writeback, and divide results only in the memory stage. A match against a producer whose result cannot be forwarded stalls decode. Register x0 never creates a dependency.

Top module: `hzd_bypass_unit`

## Requirements
- R1: After reset the hold register is empty. A register-file write in flight while reset was asserted is never forwarded, and with no stage valid each operand equals the register-file read data and `dec_stall` is 0.
- R2: A source index of 0 never stalls, and its operand is 0, whatever the producers hold.
- R3: A source whose use flag is 0 never causes `dec_stall`.
- R4: When the execute stage is valid, has write enable set, is ready, and has a destination equal to a nonzero source index, and its forwarding is enabled, the operand equals `ex_result` with no stall.
- R5: The same holds for the memory stage (`mem_result`) when no execute match exists.
- R6: The same holds for the writeback stage (`wb_result`) when neither execute nor memory matches.
- R7: A register-file write made on the previous cycle (`wb_valid` and `wb_wr_en` high at the last clock edge) is forwarded from the hold register when no pipeline stage matches and hold forwarding is enabled.
- R8: When several producers match a source, only the youngest counts, in the order execute, memory, writeback, hold.
- R9: If the youngest matching producer has its ready flag low, a used source stalls, even when an older stage holds a ready value.
- R10: If the youngest matching producer has its forwarding disabled by parameter, a used source stalls.
- R11: `dec_stall` is high when either source requires a stall.
- R12: A producer with its valid or write-enable flag low never matches; the operand falls back to the register-file data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dec_rs1_idx | input | IDX_W | Decode source 1 register index |
| dec_rs2_idx | input | IDX_W | Decode source 2 register index |
| dec_rs1_use | input | 1 | Decode instruction reads source 1 |
| dec_rs2_use | input | 1 | Decode instruction reads source 2 |
| rf_rs1_data | input | DATA_W | Register-file read data for source 1 |
| rf_rs2_data | input | DATA_W | Register-file read data for source 2 |
| ex_valid | input | 1 | Execute stage holds an instruction |
| ex_wr_en | input | 1 | Execute instruction writes a register |
| ex_rd | input | IDX_W | Execute destination index |
| ex_result | input | DATA_W | Execute result value |
| ex_ready | input | 1 | Execute result is final |
| mem_valid | input | 1 | Memory stage holds an instruction |
| mem_wr_en | input | 1 | Memory instruction writes a register |
| mem_rd | input | IDX_W | Memory destination index |
| mem_result | input | DATA_W | Memory result value |
| mem_ready | input | 1 | Memory result is final |
| wb_valid | input | 1 | Writeback stage holds an instruction |
| wb_wr_en | input | 1 | Writeback writes the register file this cycle |
| wb_rd | input | IDX_W | Writeback destination index |
| wb_result | input | DATA_W | Writeback value |
| wb_ready | input | 1 | Writeback value is final |
| op1_data | output | DATA_W | Resolved source 1 operand |
| op2_data | output | DATA_W | Resolved source 2 operand |
| dec_stall | output | 1 | Hold the decode stage this cycle |

## Verification
Directed patterns place one matching producer at a time in execute, memory, writeback and the hold register. This separates the four forwarding paths, and a mismatch shows up as a wrong operand value. Overlapping matches in two or three stages test youngest-first priority. A not-ready execute match over a ready older one shows that readiness is judged only on the winning producer. Two instances run side by side, one with all forwarding on and one with all off, so the same stimulus must forward in one and stall in the other. A long stretch of pseudo-random traffic over a small set of register indices then compares every cycle against a behavioural model, covering x0, unused sources and disabled valid or write-enable flags.

// File: rtl/hzd_pkg.sv
package hzd_pkg;
  localparam int NUM_PROD = 4;
  localparam int NUM_SRC  = 2;

  // producer slots, youngest first
  typedef enum int {
    PROD_EX   = 0,
    PROD_MEM  = 1,
    PROD_WB   = 2,
    PROD_HOLD = 3
  } prod_e;

  // keep only the lowest set bit: the youngest matching producer
  function automatic logic [NUM_PROD-1:0] pick_youngest(input logic [NUM_PROD-1:0] hits);
    return hits & (~hits + 1'b1);
  endfunction
endpackage

// File: rtl/hzd_wb_hold.sv
module hzd_wb_hold #(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wb_fire,
  input  logic [IDX_W-1:0]  wb_rd,
  input  logic [DATA_W-1:0] wb_data,
  output logic              hold_valid,
  output logic [IDX_W-1:0]  hold_rd,
  output logic [DATA_W-1:0] hold_data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_valid <= 1'b0;
      hold_rd    <= '0;
      hold_data  <= '0;
    end else begin
      hold_valid <= wb_fire;
      if (wb_fire) begin
        hold_rd   <= wb_rd;
        hold_data <= wb_data;
      end
    end
  end

  // R7
  hold_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_fire |=> (hold_valid && hold_rd == $past(wb_rd) && hold_data == $past(wb_data)));

  // R7
  hold_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wb_fire |=> !hold_valid);
endmodule

// File: rtl/hzd_src_resolve.sv
module hzd_src_resolve
  import hzd_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 5,
  parameter logic [NUM_PROD-1:0] BYP_MASK = '1
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [IDX_W-1:0]                 src_idx,
  input  logic                             src_use,
  input  logic [DATA_W-1:0]                rf_data,
  input  logic [NUM_PROD-1:0]              prod_wr,
  input  logic [NUM_PROD-1:0][IDX_W-1:0]   prod_rd,
  input  logic [NUM_PROD-1:0][DATA_W-1:0]  prod_data,
  input  logic [NUM_PROD-1:0]              prod_ready,
  output logic [DATA_W-1:0]                opnd,
  output logic                             stall
);
  // named internal events
  logic [NUM_PROD-1:0] hit_vec;
  logic [NUM_PROD-1:0] sel_vec;
  logic                fwd_ok;
  logic                blocked;
  logic [DATA_W-1:0]   fwd_data;
  logic                src_zero;

  assign src_zero = (src_idx == '0);

  always_comb begin
    for (int k = 0; k < NUM_PROD; k++) begin
      hit_vec[k] = prod_wr[k] && (prod_rd[k] == src_idx) && !src_zero;
    end
  end

  assign sel_vec = pick_youngest(hit_vec);
  assign fwd_ok  = |(sel_vec & BYP_MASK & prod_ready);
  assign blocked = |sel_vec && !fwd_ok;

  always_comb begin
    fwd_data = '0;
    for (int k = 0; k < NUM_PROD; k++) begin
      fwd_data = fwd_data | ({DATA_W{sel_vec[k]}} & prod_data[k]);
    end
  end

  always_comb begin
    if (src_zero)    opnd = '0;
    else if (fwd_ok) opnd = fwd_data;
    else             opnd = rf_data;
  end

  assign stall = src_use && blocked;

  // R2
  x0_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src_idx == '0) |-> (opnd == '0 && !stall));

  // R3
  unused_nostall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !src_use |-> !stall);

  // R9
  notready_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src_use && src_idx != '0 && prod_wr[PROD_EX] && prod_rd[PROD_EX] == src_idx
     && !prod_ready[PROD_EX]) |-> stall);

  // R8
  youngest_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel_vec));
endmodule

// File: rtl/hzd_bypass_unit.sv
module hzd_bypass_unit
  import hzd_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 5,
  parameter bit BYP_EX   = 1'b1,
  parameter bit BYP_MEM  = 1'b1,
  parameter bit BYP_WB   = 1'b1,
  parameter bit BYP_HOLD = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  dec_rs1_idx,
  input  logic [IDX_W-1:0]  dec_rs2_idx,
  input  logic              dec_rs1_use,
  input  logic              dec_rs2_use,
  input  logic [DATA_W-1:0] rf_rs1_data,
  input  logic [DATA_W-1:0] rf_rs2_data,
  input  logic              ex_valid,
  input  logic              ex_wr_en,
  input  logic [IDX_W-1:0]  ex_rd,
  input  logic [DATA_W-1:0] ex_result,
  input  logic              ex_ready,
  input  logic              mem_valid,
  input  logic              mem_wr_en,
  input  logic [IDX_W-1:0]  mem_rd,
  input  logic [DATA_W-1:0] mem_result,
  input  logic              mem_ready,
  input  logic              wb_valid,
  input  logic              wb_wr_en,
  input  logic [IDX_W-1:0]  wb_rd,
  input  logic [DATA_W-1:0] wb_result,
  input  logic              wb_ready,
  output logic [DATA_W-1:0] op1_data,
  output logic [DATA_W-1:0] op2_data,
  output logic              dec_stall
);
  localparam logic [NUM_PROD-1:0] BYP_MASK = {BYP_HOLD, BYP_WB, BYP_MEM, BYP_EX};

  logic                             wb_fire;
  logic                             hold_valid;
  logic [IDX_W-1:0]                 hold_rd;
  logic [DATA_W-1:0]                hold_data;

  logic [NUM_PROD-1:0]              prod_wr;
  logic [NUM_PROD-1:0][IDX_W-1:0]   prod_rd;
  logic [NUM_PROD-1:0][DATA_W-1:0]  prod_data;
  logic [NUM_PROD-1:0]              prod_ready;

  logic [NUM_SRC-1:0][IDX_W-1:0]    src_idx;
  logic [NUM_SRC-1:0]               src_use;
  logic [NUM_SRC-1:0][DATA_W-1:0]   src_rf;
  logic [NUM_SRC-1:0][DATA_W-1:0]   src_opnd;
  logic [NUM_SRC-1:0]               src_stall;

  assign wb_fire = wb_valid && wb_wr_en;

  hzd_wb_hold #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_hold (
    .clk        (clk),
    .rst_n      (rst_n),
    .wb_fire    (wb_fire),
    .wb_rd      (wb_rd),
    .wb_data    (wb_result),
    .hold_valid (hold_valid),
    .hold_rd    (hold_rd),
    .hold_data  (hold_data)
  );

  always_comb begin
    prod_wr[PROD_EX]      = ex_valid && ex_wr_en;
    prod_rd[PROD_EX]      = ex_rd;
    prod_data[PROD_EX]    = ex_result;
    prod_ready[PROD_EX]   = ex_ready;
    prod_wr[PROD_MEM]     = mem_valid && mem_wr_en;
    prod_rd[PROD_MEM]     = mem_rd;
    prod_data[PROD_MEM]   = mem_result;
    prod_ready[PROD_MEM]  = mem_ready;
    prod_wr[PROD_WB]      = wb_fire;
    prod_rd[PROD_WB]      = wb_rd;
    prod_data[PROD_WB]    = wb_result;
    prod_ready[PROD_WB]   = wb_ready;
    prod_wr[PROD_HOLD]    = hold_valid;
    prod_rd[PROD_HOLD]    = hold_rd;
    prod_data[PROD_HOLD]  = hold_data;
    prod_ready[PROD_HOLD] = 1'b1;
  end

  assign src_idx = {dec_rs2_idx, dec_rs1_idx};
  assign src_use = {dec_rs2_use, dec_rs1_use};
  assign src_rf  = {rf_rs2_data, rf_rs1_data};

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    hzd_src_resolve #(
      .DATA_W   (DATA_W),
      .IDX_W    (IDX_W),
      .BYP_MASK (BYP_MASK)
    ) u_res (
      .clk        (clk),
      .rst_n      (rst_n),
      .src_idx    (src_idx[s]),
      .src_use    (src_use[s]),
      .rf_data    (src_rf[s]),
      .prod_wr    (prod_wr),
      .prod_rd    (prod_rd),
      .prod_data  (prod_data),
      .prod_ready (prod_ready),
      .opnd       (src_opnd[s]),
      .stall      (src_stall[s])
    );
  end

  assign op1_data  = src_opnd[0];
  assign op2_data  = src_opnd[1];
  assign dec_stall = |src_stall;

  // R11
  stall_any_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_rs2_use && dec_rs2_idx != '0 && ex_valid && ex_wr_en && ex_rd == dec_rs2_idx
     && !ex_ready) |-> dec_stall);
endmodule

// File: tb/sim_hzd_bypass_unit.sv
module sim_hzd_bypass_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [4:0]  rs1, rs2;
  logic        use1, use2;
  logic [31:0] rf1, rf2;
  logic        ex_valid, ex_wr_en, ex_ready;
  logic [4:0]  ex_rd;
  logic [31:0] ex_result;
  logic        mem_valid, mem_wr_en, mem_ready;
  logic [4:0]  mem_rd;
  logic [31:0] mem_result;
  logic        wb_valid, wb_wr_en, wb_ready;
  logic [4:0]  wb_rd;
  logic [31:0] wb_result;

  logic [31:0] a_op1, a_op2, b_op1, b_op2;
  logic        a_stall, b_stall;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 0;

  hzd_bypass_unit u0 (
    .clk(clk), .rst_n(rst_n),
    .dec_rs1_idx(rs1), .dec_rs2_idx(rs2), .dec_rs1_use(use1), .dec_rs2_use(use2),
    .rf_rs1_data(rf1), .rf_rs2_data(rf2),
    .ex_valid(ex_valid), .ex_wr_en(ex_wr_en), .ex_rd(ex_rd), .ex_result(ex_result), .ex_ready(ex_ready),
    .mem_valid(mem_valid), .mem_wr_en(mem_wr_en), .mem_rd(mem_rd), .mem_result(mem_result), .mem_ready(mem_ready),
    .wb_valid(wb_valid), .wb_wr_en(wb_wr_en), .wb_rd(wb_rd), .wb_result(wb_result), .wb_ready(wb_ready),
    .op1_data(a_op1), .op2_data(a_op2), .dec_stall(a_stall)
  );

  hzd_bypass_unit #(.BYP_EX(1'b0), .BYP_MEM(1'b0), .BYP_WB(1'b0), .BYP_HOLD(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n),
    .dec_rs1_idx(rs1), .dec_rs2_idx(rs2), .dec_rs1_use(use1), .dec_rs2_use(use2),
    .rf_rs1_data(rf1), .rf_rs2_data(rf2),
    .ex_valid(ex_valid), .ex_wr_en(ex_wr_en), .ex_rd(ex_rd), .ex_result(ex_result), .ex_ready(ex_ready),
    .mem_valid(mem_valid), .mem_wr_en(mem_wr_en), .mem_rd(mem_rd), .mem_result(mem_result), .mem_ready(mem_ready),
    .wb_valid(wb_valid), .wb_wr_en(wb_wr_en), .wb_rd(wb_rd), .wb_result(wb_result), .wb_ready(wb_ready),
    .op1_data(b_op1), .op2_data(b_op2), .dec_stall(b_stall)
  );

  // model of last cycle's register-file write
  logic        mh_v;
  logic [4:0]  mh_rd;
  logic [31:0] mh_d;
  always @(posedge clk) begin
    if (!rst_n) mh_v <= 1'b0;
    else begin
      mh_v <= wb_valid && wb_wr_en;
      if (wb_valid && wb_wr_en) begin
        mh_rd <= wb_rd;
        mh_d  <= wb_result;
      end
    end
  end

  // {compare_value, stall, value}
  function automatic logic [33:0] ref_src(input logic [3:0] en, input logic [4:0] idx,
                                          input logic use_s, input logic [31:0] rf);
    logic [3:0]  v;
    logic [4:0]  rd [4];
    logic [31:0] d [4];
    logic [3:0]  rdy;
    v = {mh_v, wb_valid && wb_wr_en, mem_valid && mem_wr_en, ex_valid && ex_wr_en};
    rd[0] = ex_rd;  rd[1] = mem_rd;  rd[2] = wb_rd;  rd[3] = mh_rd;
    d[0] = ex_result; d[1] = mem_result; d[2] = wb_result; d[3] = mh_d;
    rdy = {1'b1, wb_ready, mem_ready, ex_ready};
    if (idx == 5'd0) return {1'b1, 1'b0, 32'h0};
    for (int k = 0; k < 4; k++) begin
      if (v[k] && rd[k] == idx) begin
        if (en[k] && rdy[k]) return {1'b1, 1'b0, d[k]};
        return {1'b0, use_s, 32'h0};
      end
    end
    return {1'b1, 1'b0, rf};
  endfunction

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    logic [33:0] e;
    logic st;
    #1;
    st = 1'b0;
    e = ref_src(4'hF, rs1, use1, rf1); st |= e[32]; if (e[33]) chk(tag, "u0 op1", a_op1, e[31:0]);
    e = ref_src(4'hF, rs2, use2, rf2); st |= e[32]; if (e[33]) chk(tag, "u0 op2", a_op2, e[31:0]);
    chk(tag, "u0 stall", {31'b0, a_stall}, {31'b0, st});
    st = 1'b0;
    e = ref_src(4'h0, rs1, use1, rf1); st |= e[32]; if (e[33]) chk(tag, "u1 op1", b_op1, e[31:0]);
    e = ref_src(4'h0, rs2, use2, rf2); st |= e[32]; if (e[33]) chk(tag, "u1 op2", b_op2, e[31:0]);
    chk(tag, "u1 stall", {31'b0, b_stall}, {31'b0, st});
  endtask

  task automatic idle();
    rs1 = 5'd1; rs2 = 5'd2; use1 = 1'b1; use2 = 1'b1;
    rf1 = 32'h1111_0001; rf2 = 32'h2222_0002;
    ex_valid = 0; ex_wr_en = 0; ex_rd = 0; ex_result = 0; ex_ready = 1;
    mem_valid = 0; mem_wr_en = 0; mem_rd = 0; mem_result = 0; mem_ready = 1;
    wb_valid = 0; wb_wr_en = 0; wb_rd = 0; wb_result = 0; wb_ready = 1;
  endtask

  task automatic set_ex(input logic [4:0] rd, input logic [31:0] d, input logic rdy);
    ex_valid = 1; ex_wr_en = 1; ex_rd = rd; ex_result = d; ex_ready = rdy;
  endtask
  task automatic set_mem(input logic [4:0] rd, input logic [31:0] d, input logic rdy);
    mem_valid = 1; mem_wr_en = 1; mem_rd = rd; mem_result = d; mem_ready = rdy;
  endtask
  task automatic set_wb(input logic [4:0] rd, input logic [31:0] d);
    wb_valid = 1; wb_wr_en = 1; wb_rd = rd; wb_result = d; wb_ready = 1;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    idle();
    // R1: a register-file write during reset must not survive it
    set_wb(5'd7, 32'hDEAD_0007);
    repeat (3) @(negedge clk);
    idle();
    rst_n = 1'b1;
    @(negedge clk); idle(); rs1 = 5'd7; rf1 = 32'h7777_7777;
    check_all("R1");
    if (a_op1 !== 32'h7777_7777 || a_stall !== 1'b0) begin
      fails++; $display("FAIL R1 reset op1: actual %h expected 77777777", a_op1);
    end
    checks++;

    // R2: x0 source with an execute write to x0
    @(negedge clk); idle(); rs1 = 5'd0; rf1 = 32'hFFFF_FFFF; set_ex(5'd0, 32'hABCD, 1'b0);
    check_all("R2");

    // R3: unused source, not-ready match in execute
    @(negedge clk); idle(); rs1 = 5'd3; use1 = 1'b0; set_ex(5'd3, 32'h33, 1'b0);
    check_all("R3");

    // R4 / R10: execute forward, disabled instance stalls
    @(negedge clk); idle(); rs1 = 5'd4; set_ex(5'd4, 32'h4444_0004, 1'b1);
    check_all("R4");
    check_all("R10");

    // R5: memory forward on source 2
    @(negedge clk); idle(); rs2 = 5'd5; set_mem(5'd5, 32'h5555_0005, 1'b1);
    check_all("R5");

    // R6 then R7: writeback, then the hold register next cycle
    @(negedge clk); idle(); rs1 = 5'd6; set_wb(5'd6, 32'h6666_0006);
    check_all("R6");
    @(negedge clk); idle(); rs1 = 5'd6; rf1 = 32'hBAD0_BAD0;
    check_all("R7");

    // R8: priority among overlapping producers
    @(negedge clk); idle(); rs1 = 5'd9;
    set_ex(5'd9, 32'hE0E0, 1); set_mem(5'd9, 32'hA0A0, 1); set_wb(5'd9, 32'hB0B0);
    check_all("R8");
    @(negedge clk); idle(); rs1 = 5'd9; set_mem(5'd9, 32'hA1A1, 1); set_wb(5'd9, 32'hB1B1);
    check_all("R8");

    // R9: youngest not ready stalls despite a ready older stage
    @(negedge clk); idle(); rs1 = 5'd10; set_ex(5'd10, 32'h0, 1'b0); set_mem(5'd10, 32'hCC, 1'b1);
    check_all("R9");
    @(negedge clk); idle(); rs2 = 5'd11; set_mem(5'd11, 32'h0, 1'b0);
    check_all("R9");

    // R11: only source 2 blocked
    @(negedge clk); idle(); rs1 = 5'd12; rs2 = 5'd13; set_mem(5'd12, 32'hC12, 1); set_ex(5'd13, 32'h0, 0);
    check_all("R11");

    // R12: valid low, then write enable low
    @(negedge clk); idle(); rs1 = 5'd14; set_ex(5'd14, 32'hEE, 1); ex_valid = 0;
    check_all("R12");
    @(negedge clk); idle(); rs1 = 5'd14; set_mem(5'd14, 32'hEE, 1); mem_wr_en = 0;
    check_all("R12");

    // random traffic over few indices, every cycle
    for (int n = 0; n < 400; n++) begin
      @(negedge clk);
      rs1 = 5'($urandom_range(0, 3)); rs2 = 5'($urandom_range(0, 3));
      use1 = 1'($urandom); use2 = 1'($urandom);
      rf1 = $urandom; rf2 = $urandom;
      ex_valid = 1'($urandom); ex_wr_en = 1'($urandom); ex_rd = 5'($urandom_range(0, 3));
      ex_result = $urandom; ex_ready = 1'($urandom);
      mem_valid = 1'($urandom); mem_wr_en = 1'($urandom); mem_rd = 5'($urandom_range(0, 3));
      mem_result = $urandom; mem_ready = 1'($urandom);
      wb_valid = 1'($urandom); wb_wr_en = 1'($urandom); wb_rd = 5'($urandom_range(0, 3));
      wb_result = $urandom; wb_ready = 1'b1;
      check_all("R8");
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule